// File: doc/BRIEF.md
# Cartridge Authentication Handshake Responder

This block sits on the cartridge side of a console connector and answers the console's power-up identity challenge. Once the active-low reset has been released, it samples two address nibbles, the low nibble and the top nibble of the address bus, on every rising edge of the console clock. It then waits for a two-step start pattern. In the first step the low nibble reads 0xA and the top nibble reads 0x5. In the second step, on the very next sample, the two values have traded places.

After the start, the handshake output stays high for a short guard period. It then sends a fixed 22-bit identification word, one bit per clock edge, beginning with the leftmost bit. When the word has been sent, the output stays high until the next reset. All timing is counted in clock edges and never in absolute time, so the block works at whatever rate the console clock runs.

Top module: `cart_auth_responder`

## Requirements
- R1: While reset is low, the handshake output is 1. Reset releases the block into the idle state, and a handshake that was cut short by reset can be run again in full afterwards.
- R2: As long as no valid start has been sampled, the handshake output stays 1 whatever the address nibbles carry.
- R3: Arming happens on a rising edge where the low nibble is 0xA and the top nibble is 0x5. If the next rising edge samples low nibble 0x5 and top nibble 0xA, that edge is the start edge. A valid start leads to exactly 14 low output cycles.
- R4: A start is only taken when the swapped value comes straight after the arming value. Arming may repeat over several edges. Any other value disarms the block, and the swapped value seen without arming before it is ignored. In none of these cases does the output go low.
- R5: On the start edge and on the three rising edges that follow it, the output stays 1.
- R6: On rising edges 4 through 25 after the start edge, the output carries bits 21 down to 0 of the pattern 22'b1000101000101000000111, one bit per edge.
- R7: From edge 26 after the start onward, the output stays 1 until reset. Address patterns that arrive during or after the sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset from the console |
| clk | input | 1 | Console clock; all behaviour counts its rising edges |
| addr_lo | input | 4 | Low address nibble (bits 3..0) |
| addr_hi | input | 4 | Top address nibble (bits 19..16) |
| auth_n | output | 1 | Active-low handshake output, registered |

## Verification
The hardest case to reach is the strict ordering of the start detection. The arming value and the swapped value must arrive on consecutive edges. The stimulus plays back the same two values in the wrong order, with a gap between them, and with only one nibble of each matching, and then it counts the low output cycles. A second start pattern is also played into the guard window and again after the sequence has ended, to show that nothing restarts. Finally, reset is asserted in the middle of a sequence, and the bench confirms that a fresh start afterwards produces all 14 low bits again.

// File: rtl/cart_auth_responder.sv
module cart_auth_responder #(
  parameter int               SEQ_LEN     = 22,
  parameter logic [SEQ_LEN-1:0] SEQ_BITS  = 22'b1000101000101000000111,
  parameter int               GUARD_EDGES = 3,
  parameter logic [3:0]       ARM_LO      = 4'hA,
  parameter logic [3:0]       ARM_HI      = 4'h5
) (
  input  logic       rst_n,
  input  logic       clk,
  input  logic [3:0] addr_lo,
  input  logic [3:0] addr_hi,
  output logic       auth_n
);
  localparam int IW = $clog2(SEQ_LEN);
  localparam int GW = $clog2(GUARD_EDGES + 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_ARMED = 3'd1;
  localparam logic [2:0] S_GUARD = 3'd2;
  localparam logic [2:0] S_SEND  = 3'd3;
  localparam logic [2:0] S_DONE  = 3'd4;

  logic [2:0]    st;
  logic [GW-1:0] gcnt;
  logic [IW-1:0] idx;

  wire arm_seen   = (addr_lo == ARM_LO) && (addr_hi == ARM_HI);
  wire swap_seen  = (addr_lo == ARM_HI) && (addr_hi == ARM_LO);
  wire guard_last = (gcnt == GW'(GUARD_EDGES - 1));
  wire last_bit   = (idx == IW'(SEQ_LEN - 1));
  wire next_bit   = SEQ_BITS[IW'(SEQ_LEN - 1) - idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      gcnt   <= '0;
      idx    <= '0;
      auth_n <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          auth_n <= 1'b1;
          if (arm_seen) st <= S_ARMED;
        end
        S_ARMED: begin
          auth_n <= 1'b1;
          if (swap_seen) begin
            st   <= S_GUARD;
            gcnt <= '0;
          end else if (!arm_seen) begin
            st <= S_IDLE;
          end
        end
        S_GUARD: begin
          auth_n <= 1'b1;
          if (guard_last) begin
            st  <= S_SEND;
            idx <= '0;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_SEND: begin
          auth_n <= next_bit;
          if (last_bit) st <= S_DONE;
          else          idx <= idx + 1'b1;
        end
        default: begin
          st     <= S_DONE;
          auth_n <= 1'b1;
        end
      endcase
    end
  end
endmodule

module cart_auth_checks #(
  parameter int                 SEQ_LEN  = 22,
  parameter logic [SEQ_LEN-1:0] SEQ_BITS = 22'b1000101000101000000111,
  parameter logic [3:0]         ARM_LO   = 4'hA,
  parameter logic [3:0]         ARM_HI   = 4'h5,
  localparam int                IW       = $clog2(SEQ_LEN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    addr_lo,
  input logic [3:0]    addr_hi,
  input logic          auth_n,
  input logic [2:0]    st,
  input logic [IW-1:0] idx
);
  localparam logic [2:0] C_IDLE  = 3'd0;
  localparam logic [2:0] C_ARMED = 3'd1;
  localparam logic [2:0] C_GUARD = 3'd2;
  localparam logic [2:0] C_SEND  = 3'd3;
  localparam logic [2:0] C_DONE  = 3'd4;

  always @(negedge clk)
    if (!rst_n) a_r1_reset_high: assert (auth_n);

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE || st == C_ARMED) |-> auth_n);

  a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && addr_lo == ARM_LO && addr_hi == ARM_HI) |=> st == C_ARMED);

  a_r4_start_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_GUARD && $past(st) != C_GUARD) |->
      ($past(st) == C_ARMED && $past(addr_lo) == ARM_HI && $past(addr_hi) == ARM_LO));

  a_r5_guard_high: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_GUARD |=> auth_n);

  a_r6_bit_out: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_SEND |=> auth_n == SEQ_BITS[IW'(SEQ_LEN - 1) - $past(idx)]);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_DONE |=> (st == C_DONE && auth_n));
endmodule

bind cart_auth_responder cart_auth_checks #(
  .SEQ_LEN(SEQ_LEN), .SEQ_BITS(SEQ_BITS), .ARM_LO(ARM_LO), .ARM_HI(ARM_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .addr_hi(addr_hi),
  .auth_n(auth_n), .st(st), .idx(idx)
);

// File: tb/sim_cart_auth_responder.sv
`timescale 1ns/1ps
module sim_cart_auth_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a_lo = 4'h0;
  logic [3:0] a_hi = 4'h0;
  logic       auth_n;

  always #2 clk = ~clk;

  cart_auth_responder u0 (
    .rst_n(rst_n), .clk(clk), .addr_lo(a_lo), .addr_hi(a_hi), .auth_n(auth_n)
  );

  localparam logic [21:0] PAT = 22'b1000101000101000000111;

  int    n_chk = 0;
  int    n_err = 0;
  int    lows  = 0;
  int    k     = 0;
  bit    started = 0;
  bit    have_prev = 0;
  logic [3:0] p_lo, p_hi;
  logic  exp_hs = 1'b1;
  string tag  = "R1";
  string scen = "R2";

  always @(posedge clk) begin
    if (!rst_n) begin
      started = 0; have_prev = 0; exp_hs = 1'b1; tag = "R1";
    end else begin
      if (started) k++;
      else if (have_prev && p_lo == 4'hA && p_hi == 4'h5 && a_lo == 4'h5 && a_hi == 4'hA) begin
        started = 1; k = 0;
      end
      p_lo = a_lo; p_hi = a_hi; have_prev = 1;
      if (!started)    begin exp_hs = 1'b1; tag = scen; end
      else if (k < 4)  begin exp_hs = 1'b1; tag = "R5"; end
      else if (k < 26) begin exp_hs = PAT[21-(k-4)]; tag = "R6"; end
      else             begin exp_hs = 1'b1; tag = "R7"; end
    end
  end

  always @(negedge clk) begin
    n_chk++;
    if (auth_n !== exp_hs) begin
      n_err++;
      $display("FAIL %s per-cycle: auth_n=%b expected %b", tag, auth_n, exp_hs);
    end
    if (auth_n === 1'b0) lows++;
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(input logic [3:0] lo, input logic [3:0] hi, input int n);
    repeat (n) begin
      @(negedge clk); #1;
      a_lo = lo; a_hi = hi;
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset output", int'(auth_n), 1);
    #1 rst_n = 1'b1;

    scen = "R2";
    drive(4'h0, 4'h0, 4);
    drive(4'hF, 4'hF, 4);
    drive(4'hA, 4'h0, 2);
    drive(4'h0, 4'h5, 2);

    scen = "R4";
    lows = 0;
    drive(4'h5, 4'hA, 3);
    drive(4'hA, 4'h5, 1);
    drive(4'h3, 4'h3, 1);
    drive(4'h5, 4'hA, 2);
    drive(4'hA, 4'h0, 1);
    drive(4'h5, 4'hA, 1);
    drive(4'hA, 4'h5, 1);
    drive(4'h5, 4'h0, 1);
    drive(4'h0, 4'hA, 5);
    drive(4'h0, 4'h0, 3);
    chk("R4 low cycles after bad orders", lows, 0);

    scen = "R3";
    lows = 0;
    drive(4'hA, 4'h5, 3);
    drive(4'h5, 4'hA, 1);
    drive(4'hA, 4'h5, 1);
    drive(4'h5, 4'hA, 1);
    drive(4'hC, 4'hC, 30);
    chk("R3 low cycles after start", lows, 14);
    drive(4'hA, 4'h5, 1);
    drive(4'h5, 4'hA, 1);
    drive(4'h0, 4'h0, 30);
    chk("R7 no restart after done", lows, 14);

    lows = 0;
    drive(4'hA, 4'h5, 1);
    drive(4'h5, 4'hA, 1);
    drive(4'h0, 4'h0, 9);
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset mid-sequence", int'(auth_n), 1);
    #1 rst_n = 1'b1;
    scen = "R2";
    lows = 0;
    drive(4'hA, 4'h5, 1);
    drive(4'h5, 4'hA, 1);
    drive(4'h0, 4'h0, 32);
    chk("R1 full sequence after reset", lows, 14);
    chk("R7 output high at end", int'(auth_n), 1);

    finish_run();
  end
endmodule